// File: doc/BRIEF.md
# UART Receive Byte Queue with Fill Threshold and Idle Timeout

This block sits between a UART bit receiver and a register read port. Each byte the receiver presents with a valid strobe is stored in a 128-entry first-in first-out queue. The reader pops bytes with a single-cycle strobe and gets each byte on a registered data output. The queue's occupancy is reported as a fill level. That level is computed from two wrapping 7-bit pointers plus a flag that tells a completely full queue from an empty one.

Three interrupt status bits are produced. The fill bit follows the occupancy: it is set whenever more bytes are stored than a programmed threshold. The overflow bit is sticky and records a byte that arrived with no room for it. The idle-timeout bit is also sticky. It records that bytes have been waiting, with no new character arriving, for a programmed number of character times. A character-time tick marks each character time. When the tick comes from the slow reference source, the programmed count is scaled by eight. A threshold of zero turns the timeout off.

The timeout is governed by a three-state machine:
- `TO_IDLE`: the queue is empty or the timeout is disabled.
- `TO_COUNT`: character ticks are being counted since the last byte.
- `TO_FIRED`: the limit has been reached.

Its transitions are:
- idle→count: enabled and the queue holds data.
- count→idle and fired→idle: the queue empties or the timeout is disabled.
- count→count with the counter restarted: a byte arrives.
- count→fired: a tick reaches the limit.
- fired→count: a byte arrives.

Top module: `uart_rxq_top`

## Requirements
- R1: Bytes are returned in arrival order. A read strobe on a non-empty queue loads the oldest byte onto `rd_data` at the clock edge that samples the strobe.
- R2: `fill_level` equals write pointer minus read pointer when write > read, and write + 128 − read when write < read. When the pointers are equal, it is 128 if the non-empty flag is set and 0 otherwise. It reflects each push and pop right after the sampling edge.
- R3: `int_status` bit 0 is 1 exactly when `fill_level` is greater than `full_thresh`. `full_thresh` must be below 128.
- R4: With a nonzero `tout_thresh` and fast ticks, `int_status` bit 2 sets at the edge that samples the `tout_thresh`-th tick counted in `TO_COUNT` with no byte arriving. The bit then stays set.
- R5: A `tout_thresh` of 0 disables the timeout, so bit 2 never sets.
- R6: With `tout_slow` high, the limit is `tout_thresh` × 8 ticks.
- R7: Every byte on `rx_valid` restarts the timeout count from zero.
- R8: Ticks are not counted while the queue is empty.
- R9: A byte arriving while the queue holds 128 bytes is dropped and sets sticky `int_status` bit 1. This happens even if a read strobe is present in the same cycle.
- R10: A read strobe on an empty queue leaves `rd_data` and both pointers unchanged.
- R11: A 1 in `int_clr` bit 1 or bit 2 clears that status bit; a new event in the same cycle wins. `int_clr` bit 0 has no effect.
- R12: After reset, `fill_level`, `int_status` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_byte | input | 8 | Byte from the receiver |
| rx_valid | input | 1 | Strobe: `rx_byte` is a new character |
| char_tick | input | 1 | One pulse per character time |
| rd_en | input | 1 | Pop strobe |
| full_thresh | input | 7 | Fill threshold for status bit 0 |
| tout_thresh | input | 8 | Timeout in character times, 0 = off |
| tout_slow | input | 1 | Ticks from slow source: scale limit by 8 |
| int_clr | input | 3 | Clear mask for status bits 1 and 2 |
| rd_data | output | 8 | Last byte popped |
| fill_level | output | 8 | Stored byte count, 0 to 128 |
| int_status | output | 3 | Bit 0 fill, bit 1 overflow, bit 2 timeout |

## Verification
Pushes, pops and status clears take effect at the one edge that samples the strobe. The bench drives every strobe for one cycle from a falling edge and reads `fill_level`, `rd_data` and `int_status` at the next falling edge. A byte reaches the timeout machine one edge after it is stored: the machine enters `TO_COUNT` on the following edge. For that reason the bench waits two idle cycles after a push before issuing ticks, and only from then on does it count ticks toward the limit. The timeout bit is checked right after the tick just before the limit, where it must still be clear, and right after the tick that reaches the limit, where it must be set.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_COUNT = 2'd1,
        TO_FIRED = 2'd2
    } tout_state_e;

    localparam int INT_FULL = 0;
    localparam int INT_OVF  = 1;
    localparam int INT_TOUT = 2;
    localparam int INT_W    = 3;
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_req,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_req,
    output logic [DW-1:0] rd_data,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic          nonempty,
    output logic          ovf_evt
);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic          full;
    logic          do_wr;
    logic          do_rd;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign full    = nonempty && (wr_ptr == rd_ptr);
    assign do_wr   = wr_req && !full;
    assign do_rd   = rd_req && nonempty;
    assign ovf_evt = wr_req && full;

    always_ff @(posedge clk) begin
        if (do_wr) begin
            mem[wr_ptr] <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            nonempty <= 1'b0;
            rd_data  <= '0;
        end else begin
            if (do_wr) begin
                wr_ptr <= step(wr_ptr);
            end
            if (do_rd) begin
                rd_ptr  <= step(rd_ptr);
                rd_data <= mem[rd_ptr];
            end
            if (do_wr) begin
                nonempty <= 1'b1;
            end else if (do_rd && (step(rd_ptr) == wr_ptr)) begin
                nonempty <= 1'b0;
            end
        end
    end

    // R10: a pop on an empty queue moves nothing
    assert_hold_on_empty_read_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !nonempty && !wr_req) |=> ($stable(rd_ptr) && $stable(rd_data)));

    // R9: a full queue accepts no byte
    assert_no_write_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && full) |=> $stable(wr_ptr));
endmodule

// File: rtl/rxq_level.sv
module rxq_level #(
    parameter int DEPTH = 128,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic [AW-1:0] wr_ptr,
    input  logic [AW-1:0] rd_ptr,
    input  logic          nonempty,
    output logic [AW:0]   level
);
    localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

    always_comb begin
        if (wr_ptr > rd_ptr) begin
            level = {1'b0, wr_ptr} - {1'b0, rd_ptr};
        end else if (wr_ptr < rd_ptr) begin
            level = {1'b0, wr_ptr} + FULL_LVL - {1'b0, rd_ptr};
        end else begin
            level = nonempty ? FULL_LVL : '0;
        end
    end
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import uart_rxq_pkg::*;
#(
    parameter int THR_W      = 8,
    parameter int SLOW_SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             byte_in,
    input  logic             empty,
    input  logic [THR_W-1:0] thr,
    input  logic             slow,
    output logic             hit
);
    localparam int CW = THR_W + SLOW_SHIFT;

    tout_state_e    state;
    tout_state_e    state_nx;
    logic [CW-1:0]  cnt;
    logic [CW-1:0]  limit;
    logic [CW-1:0]  cnt_inc;
    logic           enabled;

    assign enabled = (thr != '0);
    assign limit   = slow ? (CW'(thr) << SLOW_SHIFT) : CW'(thr);
    assign cnt_inc = cnt + 1'b1;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= TO_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state and fire pulse
    always_comb begin
        state_nx = state;
        hit      = 1'b0;
        unique case (state)
            TO_IDLE: begin
                if (enabled && !empty) begin
                    state_nx = TO_COUNT;
                end
            end
            TO_COUNT: begin
                if (!enabled || empty) begin
                    state_nx = TO_IDLE;
                end else if (!byte_in && tick && (cnt_inc >= limit)) begin
                    hit      = 1'b1;
                    state_nx = TO_FIRED;
                end
            end
            TO_FIRED: begin
                if (!enabled || empty) begin
                    state_nx = TO_IDLE;
                end else if (byte_in) begin
                    state_nx = TO_COUNT;
                end
            end
            default: state_nx = TO_IDLE;
        endcase
    end

    // character-time counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else begin
            unique case (state)
                TO_COUNT: begin
                    if (byte_in) begin
                        cnt <= '0;
                    end else if (tick) begin
                        cnt <= cnt_inc;
                    end
                end
                default: cnt <= '0;
            endcase
        end
    end

    // R5: disabled timeout parks the machine
    assert_idle_when_disabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enabled) |=> (state == TO_IDLE));

    // R8: nothing is counted while the queue is empty
    assert_idle_when_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        empty |=> (state == TO_IDLE));

    // R4: entry into the fired state is always caused by a tick
    assert_fire_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == TO_FIRED) && ($past(state) != TO_FIRED)) |-> $past(tick));
endmodule

// File: rtl/uart_rxq_top.sv
module uart_rxq_top
    import uart_rxq_pkg::*;
#(
    parameter int DW    = 8,
    parameter int DEPTH = 128,
    parameter int THR_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DW-1:0]            rx_byte,
    input  logic                     rx_valid,
    input  logic                     char_tick,
    input  logic                     rd_en,
    input  logic [$clog2(DEPTH)-1:0] full_thresh,
    input  logic [THR_W-1:0]         tout_thresh,
    input  logic                     tout_slow,
    input  logic [INT_W-1:0]         int_clr,
    output logic [DW-1:0]            rd_data,
    output logic [$clog2(DEPTH):0]   fill_level,
    output logic [INT_W-1:0]         int_status
);
    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          nonempty;
    logic          ovf_evt;
    logic          tout_hit;
    logic          ovf_q;
    logic          tout_q;

    rxq_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_req   (rx_valid),
        .wr_data  (rx_byte),
        .rd_req   (rd_en),
        .rd_data  (rd_data),
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .nonempty (nonempty),
        .ovf_evt  (ovf_evt)
    );

    rxq_level #(.DEPTH(DEPTH), .AW(AW)) u_level (
        .wr_ptr   (wr_ptr),
        .rd_ptr   (rd_ptr),
        .nonempty (nonempty),
        .level    (fill_level)
    );

    rxq_timeout #(.THR_W(THR_W), .SLOW_SHIFT(3)) u_tout (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (char_tick),
        .byte_in (rx_valid),
        .empty   (!nonempty),
        .thr     (tout_thresh),
        .slow    (tout_slow),
        .hit     (tout_hit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q  <= 1'b0;
            tout_q <= 1'b0;
        end else begin
            ovf_q  <= ovf_evt  | (ovf_q  & ~int_clr[INT_OVF]);
            tout_q <= tout_hit | (tout_q & ~int_clr[INT_TOUT]);
        end
    end

    always_comb begin
        int_status           = '0;
        int_status[INT_FULL] = (fill_level > {1'b0, full_thresh});
        int_status[INT_OVF]  = ovf_q;
        int_status[INT_TOUT] = tout_q;
    end

    // R9: an overflow event is recorded
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> int_status[INT_OVF]);

    // R2: the level moves by at most one byte per cycle
    assert_level_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((fill_level == $past(fill_level)) ||
                          (fill_level == $past(fill_level) + 1'b1) ||
                          (fill_level == $past(fill_level) - 1'b1)));
endmodule

// File: tb/tb_uart_rxq_top.sv
`timescale 1ns/1ps
module tb_uart_rxq_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_valid = 1'b0;
    logic       char_tick = 1'b0;
    logic       rd_en = 1'b0;
    logic [6:0] full_thresh = 7'd127;
    logic [7:0] tout_thresh = '0;
    logic       tout_slow = 1'b0;
    logic [2:0] int_clr = '0;
    logic [7:0] rd_data;
    logic [7:0] fill_level;
    logic [2:0] int_status;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    uart_rxq_top dut (
        .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .char_tick(char_tick), .rd_en(rd_en), .full_thresh(full_thresh),
        .tout_thresh(tout_thresh), .tout_slow(tout_slow), .int_clr(int_clr),
        .rd_data(rd_data), .fill_level(fill_level), .int_status(int_status)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7) + 3);
    endfunction

    task automatic check(input string req, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_byte  = b;
        rx_valid = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            char_tick = 1'b1;
            @(negedge clk);
            char_tick = 1'b0;
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear(input logic [2:0] m);
        @(negedge clk);
        int_clr = m;
        @(negedge clk);
        int_clr = '0;
    endtask

    task automatic drain();
        while (fill_level != 0) pop();
        idle(2);
    endtask

    task automatic t_reset();
        check("R12 level", fill_level, 0);
        check("R12 status", int_status, 0);
        check("R12 rd_data", rd_data, 0);
    endtask

    task automatic t_order();
        push(8'hA1); push(8'hB2); push(8'hC3);
        check("R2 level after 3 pushes", fill_level, 3);
        pop(); check("R1 first byte", rd_data, 8'hA1);
        pop(); check("R1 second byte", rd_data, 8'hB2);
        pop(); check("R1 third byte", rd_data, 8'hC3);
        check("R2 level after drain", fill_level, 0);
    endtask

    task automatic t_empty_read();
        pop();
        check("R10 rd_data held on empty pop", rd_data, 8'hC3);
        check("R10 level stays 0", fill_level, 0);
        push(8'h5A);
        check("R10 level after push", fill_level, 1);
        pop();
        check("R10 pointers intact, byte returned", rd_data, 8'h5A);
    endtask

    task automatic t_threshold();
        full_thresh = 7'd4;
        for (int i = 0; i < 4; i++) push(8'(i));
        check("R3 level at threshold: bit0 clear", int_status[0], 0);
        push(8'h44);
        check("R3 level above threshold: bit0 set", int_status[0], 1);
        pop();
        check("R3 back at threshold: bit0 clear", int_status[0], 0);
        drain();
        full_thresh = 7'd127;
    endtask

    task automatic t_wrap_overflow();
        for (int i = 0; i < 128; i++) push(pat(i));
        check("R2 equal pointers with data: 128", fill_level, 128);
        check("R3 128 above 127", int_status[0], 1);
        check("R9 no overflow yet", int_status[1], 0);
        push(8'hEE);
        check("R9 overflow bit set", int_status[1], 1);
        check("R9 level unchanged", fill_level, 128);
        for (int i = 0; i < 3; i++) begin
            pop();
            check("R1 wrapped order", rd_data, pat(i));
        end
        check("R2 write below read: 125", fill_level, 125);
        clear(3'b111);
        check("R11 overflow bit cleared", int_status[1], 0);
        check("R11 fill bit ignores clear", int_status[0], 0);
        for (int i = 3; i < 128; i++) begin
            pop();
            if (rd_data != pat(i)) check("R9 dropped byte absent, order kept", rd_data, pat(i));
        end
        check("R9 last stored byte", rd_data, pat(127));
        check("R2 empty after wrap", fill_level, 0);
    endtask

    task automatic t_timeout_fast();
        tout_thresh = 8'd3; tout_slow = 1'b0;
        clear(3'b110);
        tick(5);
        check("R8 empty queue never times out", int_status[2], 0);
        push(8'h11); idle(2);
        tick(2);
        check("R4 before limit", int_status[2], 0);
        tick(1);
        check("R4 at limit", int_status[2], 1);
        clear(3'b100);
        check("R11 timeout bit cleared", int_status[2], 0);
        tick(5);
        check("R4 no refire without new byte", int_status[2], 0);
        drain();
    endtask

    task automatic t_restart();
        push(8'h22); idle(2);
        tick(2);
        push(8'h23);
        tick(2);
        check("R7 restart on new byte", int_status[2], 0);
        tick(1);
        check("R7 fires after full window", int_status[2], 1);
        drain(); clear(3'b100);
    endtask

    task automatic t_disable();
        tout_thresh = 8'd0;
        push(8'h33); idle(2);
        tick(20);
        check("R5 disabled timeout", int_status[2], 0);
        drain();
    endtask

    task automatic t_slow();
        tout_thresh = 8'd1; tout_slow = 1'b1;
        push(8'h44); idle(2);
        tick(7);
        check("R6 slow: 7 ticks not enough", int_status[2], 0);
        tick(1);
        check("R6 slow: 8 ticks fire", int_status[2], 1);
        drain(); clear(3'b100);
        tout_thresh = 8'd0; tout_slow = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_order();
        t_empty_read();
        t_threshold();
        t_wrap_overflow();
        t_timeout_fast();
        t_restart();
        t_disable();
        t_slow();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end
endmodule